// File: doc/BRIEF.md
# Data-Space Effective Address Generator

This block forms the data-space address used by load and store operations in a small 8-bit processor core. It also produces the updated pointer value for the auto-modifying addressing modes. The register file, the I/O registers and the SRAM share one linear address space. The block classifies each address it forms into one of those regions, so the core can route the access to the right place.

A request carries the following:
- an addressing mode;
- a choice of one of three register-pair pointers (X, Y or Z), given as the low and high bytes read from the pair;
- a 6-bit displacement and a 16-bit direct address;
- a flag marking an I/O-instruction access, with its 6-bit I/O address;
- a write flag.

One clock later the block presents the 8-bit effective address and its region. It also presents a write enable that is already gated for unmapped addresses, and a flag that tells the core to return zero for an unmapped read. For pre-decrement and post-increment it presents the new 16-bit pointer, a write-back enable and the index of the low register of the pair. The register file and SRAM storage are not part of the block.

Top module: `ds_addr_gen`

## Requirements
- R1: The region is decoded from the full 16-bit effective address. Addresses 0x0000–0x001F give region code 0 (register file). Addresses 0x0020–0x005F give code 1 (I/O). Addresses 0x0060–0x00DF give code 2 (SRAM). Every address above 0x00DF gives code 3 (unmapped). `ea_o` carries the low 8 bits of the effective address.
- R2: The pointer is {`ptr_hi_i`, `ptr_lo_i`}. The pointer codes on `ptr_sel_i` are X=0, Y=1 and Z=2. The write-back low-register index on `ptr_idx_o` is 26 for X, 28 for Y and 30 for Z; the high byte belongs to the next register.
- R3: Mode code 0 (direct) uses `dir_addr_i` as the effective address and performs no pointer write-back.
- R4: Mode code 1 (indirect) uses the pointer as the effective address and performs no pointer write-back.
- R5: Mode code 2 (displacement) adds the unsigned 6-bit `disp_i` (0–63) to the Y or Z pointer, with no write-back. With X selected the request is treated as unmapped (code 3).
- R6: Mode code 3 (pre-decrement) uses pointer−1 as the address and writes back pointer−1. The value wraps modulo 2^16, so 0x0000 becomes 0xFFFF.
- R7: Mode code 4 (post-increment) uses the original pointer as the address and writes back pointer+1. The value wraps modulo 2^16, so 0xFFFF becomes 0x0000.
- R8: When `io_op_i` is 1, the address is `io_addr_i` + 0x20, whatever the mode. The region is then I/O (code 1) and no pointer write-back occurs.
- R9: `wr_en_o` is 1 only for a write request whose region is not code 3. `rd_zero_o` is 1 exactly for a read request whose region is code 3.
- R10: Outputs appear one clock after a request with `req_i` high. In a cycle following no request, `valid_o`, `wr_en_o`, `rd_zero_o` and `ptr_we_o` are 0. All outputs are 0 during reset.
- R11: Mode codes 5–7, and pointer code 3 in any pointer mode (codes 1–4), give region code 3 and no pointer write-back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Address request this cycle |
| write_i | input | 1 | 1 = store, 0 = load |
| mode_i | input | 3 | Addressing mode code |
| ptr_sel_i | input | 2 | Pointer select (X=0, Y=1, Z=2) |
| ptr_lo_i | input | 8 | Low byte of the selected pointer pair |
| ptr_hi_i | input | 8 | High byte of the selected pointer pair |
| disp_i | input | 6 | Unsigned displacement |
| dir_addr_i | input | 16 | Direct address |
| io_op_i | input | 1 | I/O-instruction access |
| io_addr_i | input | 6 | I/O-space address |
| valid_o | output | 1 | Result valid |
| ea_o | output | 8 | Effective address, low byte |
| region_o | output | 2 | Region code |
| wr_en_o | output | 1 | Gated write enable |
| rd_zero_o | output | 1 | Unmapped read, return zero |
| ptr_we_o | output | 1 | Pointer write-back enable |
| ptr_idx_o | output | 5 | Low register index of the pair written back |
| ptr_new_o | output | 16 | Updated pointer value |

## Verification
The clocked properties assume that the request inputs hold known values in any cycle where `req_i` is high. The post-increment and pre-decrement properties assume that the pointer bytes are the operands of that same request.

The stimulus changes the inputs only half a period away from the rising edge and keeps `req_i` low throughout reset. Beyond that, it deliberately drives every mode code, the unused pointer code and the invalid mode codes. Pointer values are biased toward the region boundaries and toward the 16-bit wrap points.

// File: rtl/ds_addr_pkg.sv
package ds_addr_pkg;

    typedef enum logic [2:0] {
        AM_DIRECT  = 3'd0,
        AM_IND     = 3'd1,
        AM_DISP    = 3'd2,
        AM_PREDEC  = 3'd3,
        AM_POSTINC = 3'd4
    } amode_e;

    typedef enum logic [1:0] {
        PS_X    = 2'd0,
        PS_Y    = 2'd1,
        PS_Z    = 2'd2,
        PS_NONE = 2'd3
    } psel_e;

    typedef enum logic [1:0] {
        RG_REG  = 2'd0,
        RG_IO   = 2'd1,
        RG_SRAM = 2'd2,
        RG_NONE = 2'd3
    } region_e;

endpackage

// File: rtl/ds_ptr_unit.sv
module ds_ptr_unit
    import ds_addr_pkg::*;
#(
    parameter int PTR_W        = 16,
    parameter int DISP_W       = 6,
    parameter int IOA_W        = 6,
    parameter int IDX_W        = 5,
    parameter int IO_BASE      = 32,
    parameter int PTR_BASE_REG = 26
) (
    input  logic [2:0]       mode_i,
    input  logic [1:0]       sel_i,
    input  logic [PTR_W-1:0] ptr_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic [PTR_W-1:0] dir_i,
    input  logic             io_op_i,
    input  logic [IOA_W-1:0] io_addr_i,
    output logic [PTR_W-1:0] eff_o,
    output logic             bad_o,
    output logic             wb_en_o,
    output logic [PTR_W-1:0] wb_val_o,
    output logic [IDX_W-1:0] wb_idx_o
);

    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    logic sel_ok;
    logic [PTR_W-1:0] ptr_dec;
    logic [PTR_W-1:0] ptr_inc;

    assign sel_ok  = (sel_i != PS_NONE);
    assign ptr_dec = ptr_i - ONE;
    assign ptr_inc = ptr_i + ONE;
    assign wb_idx_o = IDX_W'(PTR_BASE_REG) + IDX_W'({sel_i, 1'b0});

    always_comb begin
        eff_o    = '0;
        bad_o    = 1'b0;
        wb_en_o  = 1'b0;
        wb_val_o = ptr_i;
        if (io_op_i) begin
            eff_o = PTR_W'(IO_BASE) + PTR_W'(io_addr_i);
        end else begin
            unique case (mode_i)
                AM_DIRECT: begin
                    eff_o = dir_i;
                end
                AM_IND: begin
                    eff_o = ptr_i;
                    bad_o = !sel_ok;
                end
                AM_DISP: begin
                    eff_o = ptr_i + PTR_W'(disp_i);
                    bad_o = !sel_ok || (sel_i == PS_X);
                end
                AM_PREDEC: begin
                    eff_o    = ptr_dec;
                    bad_o    = !sel_ok;
                    wb_en_o  = sel_ok;
                    wb_val_o = ptr_dec;
                end
                AM_POSTINC: begin
                    eff_o    = ptr_i;
                    bad_o    = !sel_ok;
                    wb_en_o  = sel_ok;
                    wb_val_o = ptr_inc;
                end
                default: begin
                    bad_o = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/ds_region_dec.sv
module ds_region_dec
    import ds_addr_pkg::*;
#(
    parameter int PTR_W   = 16,
    parameter int REG_CNT = 32,
    parameter int IO_CNT  = 64,
    parameter int MEM_CNT = 128
) (
    input  logic [PTR_W-1:0] addr_i,
    output region_e          region_o
);

    localparam int NB = 3;
    localparam int unsigned BOUND [NB] = '{REG_CNT, REG_CNT + IO_CNT, REG_CNT + IO_CNT + MEM_CNT};

    logic [NB-1:0] above;

    for (genvar i = 0; i < NB; i++) begin : g_cmp
        assign above[i] = ({1'b0, addr_i} >= (PTR_W+1)'(BOUND[i]));
    end

    always_comb begin
        logic [1:0] cnt;
        cnt = 2'd0;
        for (int i = 0; i < NB; i++) begin
            cnt = cnt + 2'(above[i]);
        end
        region_o = region_e'(cnt);
    end

    // region bounds are ordered, so the compare results form a thermometer code (R1)
    always_comb begin
        a_thermo_r1: assert (!(above[1] && !above[0]) && !(above[2] && !above[1]));
    end

endmodule

// File: rtl/ds_addr_gen.sv
module ds_addr_gen
    import ds_addr_pkg::*;
#(
    parameter int PTR_W        = 16,
    parameter int EA_W         = 8,
    parameter int DISP_W       = 6,
    parameter int IOA_W        = 6,
    parameter int IDX_W        = 5,
    parameter int REG_CNT      = 32,
    parameter int IO_CNT       = 64,
    parameter int MEM_CNT      = 128,
    parameter int PTR_BASE_REG = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              write_i,
    input  logic [2:0]        mode_i,
    input  logic [1:0]        ptr_sel_i,
    input  logic [7:0]        ptr_lo_i,
    input  logic [7:0]        ptr_hi_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic [PTR_W-1:0]  dir_addr_i,
    input  logic              io_op_i,
    input  logic [IOA_W-1:0]  io_addr_i,
    output logic              valid_o,
    output logic [EA_W-1:0]   ea_o,
    output logic [1:0]        region_o,
    output logic              wr_en_o,
    output logic              rd_zero_o,
    output logic              ptr_we_o,
    output logic [IDX_W-1:0]  ptr_idx_o,
    output logic [PTR_W-1:0]  ptr_new_o
);

    localparam int IO_BASE  = REG_CNT;
    localparam int MEM_BASE = REG_CNT + IO_CNT;
    localparam int MAP_END  = MEM_BASE + MEM_CNT;

    typedef struct packed {
        logic             valid;
        logic [EA_W-1:0]  ea;
        region_e          region;
        logic             wr_en;
        logic             rd_zero;
        logic             ptr_we;
        logic [IDX_W-1:0] idx;
        logic [PTR_W-1:0] pnew;
    } out_t;

    out_t out_d, out_q;

    logic [PTR_W-1:0] ptr_val;
    logic [PTR_W-1:0] eff;
    logic             bad;
    logic             wb_en;
    logic [PTR_W-1:0] wb_val;
    logic [IDX_W-1:0] wb_idx;
    region_e          dec_region;

    assign ptr_val = {ptr_hi_i, ptr_lo_i};

    ds_ptr_unit #(
        .PTR_W       (PTR_W),
        .DISP_W      (DISP_W),
        .IOA_W       (IOA_W),
        .IDX_W       (IDX_W),
        .IO_BASE     (IO_BASE),
        .PTR_BASE_REG(PTR_BASE_REG)
    ) u_ptr (
        .mode_i   (mode_i),
        .sel_i    (ptr_sel_i),
        .ptr_i    (ptr_val),
        .disp_i   (disp_i),
        .dir_i    (dir_addr_i),
        .io_op_i  (io_op_i),
        .io_addr_i(io_addr_i),
        .eff_o    (eff),
        .bad_o    (bad),
        .wb_en_o  (wb_en),
        .wb_val_o (wb_val),
        .wb_idx_o (wb_idx)
    );

    ds_region_dec #(
        .PTR_W  (PTR_W),
        .REG_CNT(REG_CNT),
        .IO_CNT (IO_CNT),
        .MEM_CNT(MEM_CNT)
    ) u_dec (
        .addr_i  (eff),
        .region_o(dec_region)
    );

    always_comb begin
        out_d = '0;
        if (req_i) begin
            out_d.valid   = 1'b1;
            out_d.ea      = eff[EA_W-1:0];
            out_d.region  = bad ? RG_NONE : dec_region;
            out_d.wr_en   = write_i && (out_d.region != RG_NONE);
            out_d.rd_zero = !write_i && (out_d.region == RG_NONE);
            out_d.ptr_we  = wb_en;
            out_d.idx     = wb_idx;
            out_d.pnew    = wb_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign valid_o   = out_q.valid;
    assign ea_o      = out_q.ea;
    assign region_o  = out_q.region;
    assign wr_en_o   = out_q.wr_en;
    assign rd_zero_o = out_q.rd_zero;
    assign ptr_we_o  = out_q.ptr_we;
    assign ptr_idx_o = out_q.idx;
    assign ptr_new_o = out_q.pnew;

    p_wr_mapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (valid_o && region_o != RG_NONE && !rd_zero_o));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> (!valid_o && !wr_en_o && !rd_zero_o && !ptr_we_o));

    p_postinc_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !io_op_i && mode_i == AM_POSTINC && ptr_sel_i != PS_NONE)
        |=> (ptr_we_o && ptr_new_o == $past(ptr_val) + PTR_W'(1)
             && ea_o == $past(ptr_lo_i)));

    p_predec_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !io_op_i && mode_i == AM_PREDEC && ptr_sel_i != PS_NONE)
        |=> (ptr_we_o && ptr_new_o[EA_W-1:0] == ea_o));

    p_io_region_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && io_op_i) |=> (region_o == RG_IO && !ptr_we_o));

    p_mem_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && region_o == RG_SRAM)
        |-> (int'(ea_o) >= MEM_BASE && int'(ea_o) < MAP_END));

endmodule

// File: tb/tb_ds_addr_gen.sv
module tb_ds_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        write_i = 1'b0;
    logic [2:0]  mode_i = '0;
    logic [1:0]  ptr_sel_i = '0;
    logic [7:0]  ptr_lo_i = '0;
    logic [7:0]  ptr_hi_i = '0;
    logic [5:0]  disp_i = '0;
    logic [15:0] dir_addr_i = '0;
    logic        io_op_i = 1'b0;
    logic [5:0]  io_addr_i = '0;
    logic        valid_o, wr_en_o, rd_zero_o, ptr_we_o;
    logic [7:0]  ea_o;
    logic [1:0]  region_o;
    logic [4:0]  ptr_idx_o;
    logic [15:0] ptr_new_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ds_addr_gen dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .write_i(write_i),
        .mode_i(mode_i), .ptr_sel_i(ptr_sel_i), .ptr_lo_i(ptr_lo_i),
        .ptr_hi_i(ptr_hi_i), .disp_i(disp_i), .dir_addr_i(dir_addr_i),
        .io_op_i(io_op_i), .io_addr_i(io_addr_i), .valid_o(valid_o),
        .ea_o(ea_o), .region_o(region_o), .wr_en_o(wr_en_o),
        .rd_zero_o(rd_zero_o), .ptr_we_o(ptr_we_o), .ptr_idx_o(ptr_idx_o),
        .ptr_new_o(ptr_new_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=0x%0h exp=0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic string mode_tag(bit io, int mode, int sel);
        if (io) return "R8";
        if (mode > 4) return "R11";
        if (mode != 0 && sel == 3) return "R11";
        case (mode)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic do_op(input bit wr, input int mode, input int sel, input int ptr,
                         input int disp, input int dir, input bit io, input int ioa);
        int  eff, reg_e, pnew;
        bit  bad, pwe;
        string tg;
        req_i = 1'b1; write_i = wr; mode_i = 3'(mode); ptr_sel_i = 2'(sel);
        ptr_lo_i = 8'(ptr); ptr_hi_i = 8'(ptr >> 8); disp_i = 6'(disp);
        dir_addr_i = 16'(dir); io_op_i = io; io_addr_i = 6'(ioa);
        bad = 0; pwe = 0; pnew = 0; eff = 0;
        if (io) eff = ioa + 32;
        else begin
            case (mode)
                0: eff = dir;
                1: begin eff = ptr; bad = (sel == 3); end
                2: begin eff = (ptr + disp) & 16'hFFFF; bad = (sel == 3 || sel == 0); end
                3: begin eff = (ptr - 1) & 16'hFFFF; bad = (sel == 3);
                         pwe = (sel != 3); pnew = eff; end
                4: begin eff = ptr; bad = (sel == 3); pwe = (sel != 3);
                         pnew = (ptr + 1) & 16'hFFFF; end
                default: bad = 1;
            endcase
        end
        if (bad || eff >= 224) reg_e = 3;
        else if (eff >= 96) reg_e = 2;
        else if (eff >= 32) reg_e = 1;
        else reg_e = 0;
        tg = mode_tag(io, mode, sel);
        @(negedge clk);
        req_i = 1'b0;
        chk(valid_o == 1'b1, "R10", "valid", int'(valid_o), 1);
        chk(int'(region_o) == reg_e, (reg_e == 3 && bad) ? tg : "R1", "region",
            int'(region_o), reg_e);
        if (reg_e != 3) chk(int'(ea_o) == (eff & 255), tg, "ea", int'(ea_o), eff & 255);
        chk(wr_en_o == (wr && reg_e != 3), "R9", "wr_en", int'(wr_en_o),
            int'(wr && reg_e != 3));
        chk(rd_zero_o == (!wr && reg_e == 3), "R9", "rd_zero", int'(rd_zero_o),
            int'(!wr && reg_e == 3));
        chk(ptr_we_o == pwe, tg, "ptr_we", int'(ptr_we_o), int'(pwe));
        if (pwe) begin
            chk(int'(ptr_new_o) == pnew, tg, "ptr_new", int'(ptr_new_o), pnew);
            chk(int'(ptr_idx_o) == 26 + 2 * sel, "R2", "ptr_idx", int'(ptr_idx_o), 26 + 2 * sel);
        end
    endtask

    task automatic idle_chk();
        req_i = 1'b0;
        @(negedge clk);
        chk(!valid_o && !wr_en_o && !rd_zero_o && !ptr_we_o, "R10", "idle outputs",
            int'({valid_o, wr_en_o, rd_zero_o, ptr_we_o}), 0);
    endtask

    function automatic int pick_ptr();
        int k;
        k = int'($urandom % 10);
        case (k)
            0: return int'($urandom % 4);
            1: return 16'hFFFC + int'($urandom % 4);
            2: return 30 + int'($urandom % 4);
            3: return 94 + int'($urandom % 4);
            4: return 222 + int'($urandom % 4);
            5: return int'($urandom % 256);
            default: return int'($urandom % 65536);
        endcase
    endfunction

    initial begin
        void'($urandom(32'd24681));
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!valid_o && !wr_en_o && !rd_zero_o && !ptr_we_o && ptr_new_o == 0 && ea_o == 0,
            "R10", "reset outputs", int'({valid_o, wr_en_o, ptr_we_o}), 0);
        rst_n = 1'b1;
        idle_chk();
        // R1 boundaries through direct mode (R3)
        do_op(1, 0, 0, 0, 0, 16'h001F, 0, 0);
        do_op(1, 0, 0, 0, 0, 16'h0020, 0, 0);
        do_op(1, 0, 0, 0, 0, 16'h005F, 0, 0);
        do_op(1, 0, 0, 0, 0, 16'h0060, 0, 0);
        do_op(1, 0, 0, 0, 0, 16'h00DF, 0, 0);
        do_op(1, 0, 0, 0, 0, 16'h00E0, 0, 0);   // R9 write suppressed
        do_op(0, 0, 0, 0, 0, 16'h0160, 0, 0);   // R9 read-zero, high byte nonzero
        // R4 indirect through Z
        do_op(0, 1, 2, 16'h0075, 0, 0, 0, 0);
        // R5 displacement on Y at max, and X rejected
        do_op(1, 2, 1, 16'h00A0, 63, 0, 0, 0);
        do_op(1, 2, 0, 16'h0040, 5, 0, 0, 0);
        // R6 pre-decrement wrap, R7 post-increment wrap, R2 indices
        do_op(0, 3, 0, 16'h0000, 0, 0, 0, 0);
        do_op(1, 3, 1, 16'h0060, 0, 0, 0, 0);
        do_op(0, 4, 2, 16'hFFFF, 0, 0, 0, 0);
        do_op(1, 4, 0, 16'h00DF, 0, 0, 0, 0);
        // R8 I/O overrides post-increment mode
        do_op(1, 4, 1, 16'h1234, 0, 0, 1, 63);
        do_op(0, 0, 0, 0, 0, 16'h00F0, 1, 0);
        // R11 invalid mode and selector
        do_op(1, 5, 1, 16'h0070, 0, 0, 0, 0);
        do_op(1, 7, 2, 16'h0070, 0, 0, 0, 0);
        do_op(1, 3, 3, 16'h0070, 0, 0, 0, 0);
        idle_chk();
        for (int n = 0; n < 600; n++) begin
            if ($urandom % 8 == 0) idle_chk();
            do_op(1'($urandom), int'($urandom % 8), int'($urandom % 4), pick_ptr(),
                  int'($urandom % 64), pick_ptr(), ($urandom % 8) == 0,
                  int'($urandom % 64));
        end
        idle_chk();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R10 watchdog act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule